// File: doc/BRIEF.md
# Pipeline Hazard and Operand Bypass Unit

This block is the interlock and bypass decision logic for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) with a latch between each pair of neighbouring stages. It is purely combinational. It looks at the register numbers and control bits held in those latches and decides three things in the same cycle:

- where each of the two execute-stage operands comes from;
- whether the front of the pipeline must hold while a no-op is pushed into execute;
- whether a wrongly fetched instruction behind a taken branch must be turned into a no-op.

Bypassing can be enabled or disabled at run time. When it is off, a dependent instruction waits in decode until its producer reaches writeback. The register file writes in the first half of the cycle, so a read in the same cycle already sees the new value. A load result is never usable by the instruction right behind it.

Branches are resolved in decode against register-file values. A branch therefore waits for any producer still in execute or memory, whatever the bypass setting. In delayed-branch mode the instruction after a branch always runs. Otherwise, a taken branch discards it.

There are 16 registers, and register 0 is hard-wired to zero.

Top module: `hazard_bypass_unit`

## Requirements
- R1: With bypass enabled, an execute operand whose register matches a writing, non-load, nonzero destination in the execute/memory latch selects code 1 (execute/memory result). This match wins over a match in the memory/writeback latch. Code 3 is never produced.
- R2: With bypass enabled, an execute operand that matches only a writing, nonzero destination in the memory/writeback latch selects code 2. With no match it selects code 0 (register file).
- R3: A destination of register 0 never produces a bypass select other than 0 and never causes a stall.
- R4: With bypass enabled, a used decode source that matches the nonzero destination of a load in the execute stage raises the stall outputs. A matching non-load in execute does not stall a non-branch.
- R5: With bypass disabled, both selects are 0. A used decode source that matches a writing nonzero destination in execute or memory stalls. A match only in writeback does not stall.
- R6: A decode source whose use flag is 0 never causes a stall.
- R7: A branch in decode stalls when one of its used sources matches a writing nonzero destination in execute or memory, in both bypass settings.
- R8: With delayed branch disabled, a taken, non-stalled branch in decode raises flushId. A not-taken branch does not.
- R9: With delayed branch enabled, flushId stays 0.
- R10: While the stall outputs are high, flushId is 0.
- R11: stallIf, stallId and bubbleEx are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fwdEnable | input | 1 | 1 enables operand bypassing |
| delayBranchEn | input | 1 | 1 selects delayed-branch mode |
| idRs1 | input | 4 | first source register of the decode instruction |
| idRs2 | input | 4 | second source register of the decode instruction |
| idUsesRs1 | input | 1 | decode instruction reads idRs1 |
| idUsesRs2 | input | 1 | decode instruction reads idRs2 |
| idBranch | input | 1 | decode instruction is a conditional branch or jump |
| branchTaken | input | 1 | resolved outcome of the decode branch |
| exRs1 | input | 4 | first source register in the decode/execute latch |
| exRs2 | input | 4 | second source register in the decode/execute latch |
| exRd | input | 4 | destination in the decode/execute latch |
| exRegWrite | input | 1 | execute instruction writes exRd |
| exIsLoad | input | 1 | execute instruction is a load |
| memRd | input | 4 | destination in the execute/memory latch |
| memRegWrite | input | 1 | memory-stage instruction writes memRd |
| memIsLoad | input | 1 | memory-stage instruction is a load |
| wbRd | input | 4 | destination in the memory/writeback latch |
| wbRegWrite | input | 1 | writeback instruction writes wbRd |
| fwdSelA | output | 2 | operand A source: 0 register file, 1 execute/memory, 2 memory/writeback |
| fwdSelB | output | 2 | operand B source, same coding |
| stallIf | output | 1 | hold the program counter |
| stallId | output | 1 | hold the fetch/decode latch |
| bubbleEx | output | 1 | load a no-op into the decode/execute latch |
| flushId | output | 1 | turn the fetch/decode latch into a no-op |

## Verification
The bench targets several corner cases, each tied to a specific failure:

- Both bypass latches hold the same destination. A design with the priority reversed would feed the older writeback value into execute.
- The destination is register 0. A design without that guard would bypass or stall on a register that is never written.
- A load is followed by a dependent instruction, and a non-load is followed by a dependent instruction. One failure is missing the delayed-load stall; the other is stalling needlessly.
- Bypass is disabled with the producer in writeback. A design that ignores the half-cycle write would stall one cycle too long.
- A taken branch that is itself stalled, and one in delayed mode. A wrong design would discard the slot instruction or a still-needed fetch.

// File: rtl/hbu_pkg.sv
package hbu_pkg;
  localparam int REG_W   = 4;
  localparam int NUM_SRC = 2;

  typedef enum logic [1:0] {
    SRC_REGFILE = 2'd0,
    SRC_EXMEM   = 2'd1,
    SRC_MEMWB   = 2'd2
  } srcSel_e;

  // decode-stage dependency hits reported by the datapath
  typedef struct packed {
    logic [NUM_SRC-1:0] hitEx;
    logic [NUM_SRC-1:0] hitExLoad;
    logic [NUM_SRC-1:0] hitMem;
  } idHits_t;

  // strobes sent from control to the datapath
  typedef struct packed {
    logic useBypass;
  } ctrlStrobe_t;
endpackage

// File: rtl/hbu_bypass_path.sv
module hbu_bypass_path
  import hbu_pkg::*;
#(
  parameter int RW = REG_W
) (
  input  logic [RW-1:0]      idRs   [NUM_SRC],
  input  logic [RW-1:0]      exRs   [NUM_SRC],
  input  logic [RW-1:0]      exRd,
  input  logic               exRegWrite,
  input  logic               exIsLoad,
  input  logic [RW-1:0]      memRd,
  input  logic               memRegWrite,
  input  logic               memIsLoad,
  input  logic [RW-1:0]      wbRd,
  input  logic               wbRegWrite,
  input  ctrlStrobe_t        strobe,
  output idHits_t            hits,
  output srcSel_e            opSel  [NUM_SRC]
);
  localparam logic [RW-1:0] ZERO_REG = '0;

  logic exWrites, memWrites, memBypassable, wbWrites;

  assign exWrites      = exRegWrite  && (exRd  != ZERO_REG);
  assign memWrites     = memRegWrite && (memRd != ZERO_REG);
  assign memBypassable = memWrites && !memIsLoad;
  assign wbWrites      = wbRegWrite  && (wbRd  != ZERO_REG);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign hits.hitEx[i]     = exWrites  && (exRd  == idRs[i]);
    assign hits.hitExLoad[i] = exWrites  && exIsLoad && (exRd == idRs[i]);
    assign hits.hitMem[i]    = memWrites && (memRd == idRs[i]);

    always_comb begin
      opSel[i] = SRC_REGFILE;
      if (strobe.useBypass) begin
        if (memBypassable && (memRd == exRs[i]))
          opSel[i] = SRC_EXMEM;
        else if (wbWrites && (wbRd == exRs[i]))
          opSel[i] = SRC_MEMWB;
      end
    end
  end
endmodule

// File: rtl/hbu_hazard_ctrl.sv
module hbu_hazard_ctrl
  import hbu_pkg::*;
(
  input  idHits_t            hits,
  input  logic [NUM_SRC-1:0] idUses,
  input  logic               idBranch,
  input  logic               branchTaken,
  input  logic               fwdEnable,
  input  logic               delayBranchEn,
  output ctrlStrobe_t        strobe,
  output logic               stallIf,
  output logic               stallId,
  output logic               bubbleEx,
  output logic               flushId
);
  logic loadUse, depEx, depMem, holdFront;

  assign loadUse = |(hits.hitExLoad & idUses);
  assign depEx   = |(hits.hitEx     & idUses);
  assign depMem  = |(hits.hitMem    & idUses);

  always_comb begin
    if (fwdEnable)
      holdFront = loadUse || (idBranch && (depEx || depMem));
    else
      holdFront = depEx || depMem;
  end

  assign strobe.useBypass = fwdEnable;
  assign stallIf  = holdFront;
  assign stallId  = holdFront;
  assign bubbleEx = holdFront;
  assign flushId  = idBranch && branchTaken && !delayBranchEn && !holdFront;
endmodule

// File: rtl/hazard_bypass_unit.sv
module hazard_bypass_unit
  import hbu_pkg::*;
(
  input  logic             fwdEnable,
  input  logic             delayBranchEn,
  input  logic [REG_W-1:0] idRs1,
  input  logic [REG_W-1:0] idRs2,
  input  logic             idUsesRs1,
  input  logic             idUsesRs2,
  input  logic             idBranch,
  input  logic             branchTaken,
  input  logic [REG_W-1:0] exRs1,
  input  logic [REG_W-1:0] exRs2,
  input  logic [REG_W-1:0] exRd,
  input  logic             exRegWrite,
  input  logic             exIsLoad,
  input  logic [REG_W-1:0] memRd,
  input  logic             memRegWrite,
  input  logic             memIsLoad,
  input  logic [REG_W-1:0] wbRd,
  input  logic             wbRegWrite,
  output logic [1:0]       fwdSelA,
  output logic [1:0]       fwdSelB,
  output logic             stallIf,
  output logic             stallId,
  output logic             bubbleEx,
  output logic             flushId
);
  logic [REG_W-1:0] idRsArr [NUM_SRC];
  logic [REG_W-1:0] exRsArr [NUM_SRC];
  srcSel_e          selArr  [NUM_SRC];
  idHits_t          hits;
  ctrlStrobe_t      strobe;

  assign idRsArr[0] = idRs1;
  assign idRsArr[1] = idRs2;
  assign exRsArr[0] = exRs1;
  assign exRsArr[1] = exRs2;

  hbu_bypass_path #(.RW(REG_W)) u_path (
    .idRs(idRsArr), .exRs(exRsArr),
    .exRd(exRd), .exRegWrite(exRegWrite), .exIsLoad(exIsLoad),
    .memRd(memRd), .memRegWrite(memRegWrite), .memIsLoad(memIsLoad),
    .wbRd(wbRd), .wbRegWrite(wbRegWrite),
    .strobe(strobe), .hits(hits), .opSel(selArr)
  );

  hbu_hazard_ctrl u_ctrl (
    .hits(hits), .idUses({idUsesRs2, idUsesRs1}),
    .idBranch(idBranch), .branchTaken(branchTaken),
    .fwdEnable(fwdEnable), .delayBranchEn(delayBranchEn),
    .strobe(strobe), .stallIf(stallIf), .stallId(stallId),
    .bubbleEx(bubbleEx), .flushId(flushId)
  );

  assign fwdSelA = selArr[0];
  assign fwdSelB = selArr[1];
endmodule

// File: rtl/hazard_bypass_unit_chk.sv
module hazard_bypass_unit_chk (
  input logic       fwdEnable,
  input logic       delayBranchEn,
  input logic [3:0] memRd,
  input logic [3:0] wbRd,
  input logic [1:0] fwdSelA,
  input logic [1:0] fwdSelB,
  input logic       stallIf,
  input logic       stallId,
  input logic       bubbleEx,
  input logic       flushId
);
  always_comb begin
    if (!$isunknown({fwdEnable, delayBranchEn, memRd, wbRd, fwdSelA, fwdSelB,
                     stallIf, stallId, bubbleEx, flushId})) begin
      AST_STALL_TRIO: assert (stallIf == stallId && stallId == bubbleEx); // R11
      AST_NO_BYPASS_WHEN_OFF: assert (fwdEnable || (fwdSelA == 2'd0 && fwdSelB == 2'd0)); // R5
      AST_SEL_CODE_LEGAL: assert (fwdSelA != 2'd3 && fwdSelB != 2'd3); // R1
      AST_ZERO_DEST_NO_BYPASS: assert (!((fwdSelA == 2'd1 || fwdSelB == 2'd1) && memRd == 4'd0)
                                       && !((fwdSelA == 2'd2 || fwdSelB == 2'd2) && wbRd == 4'd0)); // R3
      AST_FLUSH_NOT_STALLED: assert (!(flushId && stallId)); // R10
      AST_DELAY_NO_FLUSH: assert (!(flushId && delayBranchEn)); // R9
    end
  end
endmodule

bind hazard_bypass_unit hazard_bypass_unit_chk u_chk (
  .fwdEnable(fwdEnable), .delayBranchEn(delayBranchEn),
  .memRd(memRd), .wbRd(wbRd), .fwdSelA(fwdSelA), .fwdSelB(fwdSelB),
  .stallIf(stallIf), .stallId(stallId), .bubbleEx(bubbleEx), .flushId(flushId)
);

// File: tb/hazard_bypass_unit_tb.sv
module hazard_bypass_unit_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic fwdEnable, delayBranchEn, idUsesRs1, idUsesRs2, idBranch, branchTaken;
  logic exRegWrite, exIsLoad, memRegWrite, memIsLoad, wbRegWrite;
  logic [3:0] idRs1, idRs2, exRs1, exRs2, exRd, memRd, wbRd;
  logic [1:0] fwdSelA, fwdSelB;
  logic stallIf, stallId, bubbleEx, flushId;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 0;

  hazard_bypass_unit u_dut (.*);

  task automatic idle();
    fwdEnable = 1; delayBranchEn = 0; idUsesRs1 = 0; idUsesRs2 = 0;
    idBranch = 0; branchTaken = 0; exRegWrite = 0; exIsLoad = 0;
    memRegWrite = 0; memIsLoad = 0; wbRegWrite = 0;
    idRs1 = 0; idRs2 = 0; exRs1 = 0; exRs2 = 0; exRd = 0; memRd = 0; wbRd = 0;
  endtask

  // expected operand source from the requirements (R1, R2, R3, R5)
  function automatic logic [1:0] expSel(input logic [3:0] rs);
    if (!fwdEnable) return 2'd0;
    if (memRegWrite && !memIsLoad && memRd != 0 && memRd == rs) return 2'd1;
    if (wbRegWrite && wbRd != 0 && wbRd == rs) return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic srcWaits(input logic [3:0] rs, input logic used);
    logic inEx, inMem;
    inEx  = used && exRegWrite  && exRd  != 0 && exRd  == rs;
    inMem = used && memRegWrite && memRd != 0 && memRd == rs;
    if (!fwdEnable || idBranch) return inEx || inMem;   // R5, R7
    return inEx && exIsLoad;                           // R4
  endfunction

  function automatic logic [7:0] expected();
    logic st, fl;
    st = srcWaits(idRs1, idUsesRs1) || srcWaits(idRs2, idUsesRs2);
    fl = idBranch && branchTaken && !delayBranchEn && !st;
    return {expSel(exRs1), expSel(exRs2), st, st, st, fl};
  endfunction

  task automatic check(input string tag, input logic [7:0] exp);
    logic [7:0] got;
    @(posedge clk); #1;
    got = {fwdSelA, fwdSelB, stallIf, stallId, bubbleEx, flushId};
    nTests++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      nFail++; nTests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle();
    check("reset/idle state", 8'b0000_0000);

    // R1: EX/MEM wins over MEM/WB
    idle(); exRs1 = 5; exRs2 = 5; memRd = 5; memRegWrite = 1; wbRd = 5; wbRegWrite = 1;
    check("R1 priority", 8'b0101_0000);
    // R2: only MEM/WB matches operand B
    idle(); exRs2 = 7; wbRd = 7; wbRegWrite = 1; exRs1 = 3;
    check("R2 writeback bypass", 8'b0010_0000);
    // R1 with load in mem: falls to writeback
    idle(); exRs1 = 6; memRd = 6; memRegWrite = 1; memIsLoad = 1; wbRd = 6; wbRegWrite = 1;
    check("R1 load in mem not bypassed", 8'b1000_0000);
    // R3: destination zero
    idle(); exRs1 = 0; memRd = 0; memRegWrite = 1; wbRd = 0; wbRegWrite = 1;
    idRs1 = 0; idUsesRs1 = 1; exRd = 0; exRegWrite = 1; exIsLoad = 1;
    check("R3 register zero", 8'b0000_0000);
    // R4: load-use stall
    idle(); idRs2 = 9; idUsesRs2 = 1; exRd = 9; exRegWrite = 1; exIsLoad = 1;
    check("R4 load-use", 8'b0000_1110);
    // R4: non-load producer, no stall
    idle(); idRs2 = 9; idUsesRs2 = 1; exRd = 9; exRegWrite = 1;
    check("R4 alu producer", 8'b0000_0000);
    // R5: bypass off, producer in mem stalls, selects forced 0
    idle(); fwdEnable = 0; idRs1 = 4; idUsesRs1 = 1; memRd = 4; memRegWrite = 1;
    exRs1 = 4;
    check("R5 off mem dependency", 8'b0000_1110);
    // R5: bypass off, producer in writeback does not stall
    idle(); fwdEnable = 0; idRs1 = 4; idUsesRs1 = 1; wbRd = 4; wbRegWrite = 1; exRs2 = 4;
    check("R5 off writeback only", 8'b0000_0000);
    // R6: unused source
    idle(); fwdEnable = 0; idRs1 = 8; idUsesRs1 = 0; exRd = 8; exRegWrite = 1; exIsLoad = 1;
    check("R6 unused source", 8'b0000_0000);
    // R7: branch waits on alu producer even with bypass on; R10 no flush
    idle(); idBranch = 1; branchTaken = 1; idRs1 = 2; idUsesRs1 = 1; memRd = 2; memRegWrite = 1;
    check("R7 R10 branch stall", 8'b0000_1110);
    // R8: taken branch flushes
    idle(); idBranch = 1; branchTaken = 1; idRs1 = 2; idUsesRs1 = 1;
    check("R8 taken flush", 8'b0000_0001);
    idle(); idBranch = 1; branchTaken = 0;
    check("R8 not taken", 8'b0000_0000);
    // R9: delayed mode keeps slot
    idle(); idBranch = 1; branchTaken = 1; delayBranchEn = 1;
    check("R9 delayed slot", 8'b0000_0000);

    // random vectors on a small register window for frequent matches (R11 implied)
    for (int n = 0; n < 3000; n++) begin
      fwdEnable = 1'($urandom); delayBranchEn = 1'($urandom);
      idUsesRs1 = 1'($urandom); idUsesRs2 = 1'($urandom);
      idBranch = 1'($urandom); branchTaken = 1'($urandom);
      exRegWrite = 1'($urandom); exIsLoad = 1'($urandom);
      memRegWrite = 1'($urandom); memIsLoad = 1'($urandom); wbRegWrite = 1'($urandom);
      idRs1 = 4'($urandom % 4); idRs2 = 4'($urandom % 4);
      exRs1 = 4'($urandom % 4); exRs2 = 4'($urandom % 4);
      exRd = 4'($urandom % 4); memRd = 4'($urandom % 4); wbRd = 4'($urandom % 4);
      check("random vector", expected());
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule